// File: doc/BRIEF.md
# Eight-Line Vectored Interrupt Controller

The block sits between eight peripheral interrupt lines and a processor. Requests are synchronized, captured in a request register and filtered by a per-line mask. A fixed-priority resolver takes the most important unmasked request and compares it with the most important level still marked in service. It raises `int_o` only when the new request outranks that level, so nested service is tracked and a lower request waits until an end-of-interrupt releases the level above it.

The processor answers with two acknowledge pulses on `inta_i`. The first pulse moves the winning request into the in-service register. The second pulse returns an 8-bit vector built from a programmable base and the line number. Software reaches the block through a chip select, read and write strobes, one address bit and an 8-bit write bus. Through that port it sets the mask, the vector base and the trigger mode, issues end-of-interrupt commands, and reads back the request, in-service and mask registers. The trigger mode can be changed at any time while the block runs.

Top module: `vic_top`

## Requirements
- R1: After reset `int_o`, `vec_valid_o` and `rdata_o` are 0. The request register, in-service register and vector base are cleared, all eight lines are masked (mask = 8'hFF), the mode is edge trigger and the request register is selected for reads.
- R2: In edge mode a request is captured on a 0-to-1 change of a line. It is dropped if the line returns low before the first acknowledge, and it is not captured again while the line stays high after being acknowledged.
- R3: In level mode the request bit follows the line's level. A line still high after its acknowledge shows as pending again.
- R4: A masked line never causes `int_o`, but its request bit is still captured and can be read back.
- R5: Line 0 has the highest priority and line 7 the lowest. `int_o` is 1 exactly when the best unmasked pending line has higher priority than every in-service line.
- R6: The first `inta_i` pulse with `int_o` high sets the winner's in-service bit and clears its request bit. With `int_o` low it changes neither register and selects line 7.
- R7: The second `inta_i` pulse makes `vec_o` = {base[4:0], line[2:0]} with `vec_valid_o` high for exactly one cycle.
- R8: End-of-interrupt clears the lowest-numbered set in-service bit. If it falls in the same cycle as a first acknowledge, the clear applies to the old register and the new bit is still set.
- R9: With `cs_n_i` high, writes and reads have no effect (mask and `rdata_o` unchanged). Acknowledge cycles work regardless of `cs_n_i`.
- R10: Write with address 1 loads the mask (1 = masked). Write with address 0 decodes a command: 8'b1xxxxxxx end-of-interrupt; 8'b01xxxxxs read select (s=0 request, s=1 in-service); 8'b001bbbbb vector base; 8'b0001xxxm mode (m=1 level, m=0 edge). A read registers into `rdata_o` one cycle later: the mask for address 1, the selected register for address 0.
- R11: A mode change takes effect on the running request register without reset: going to level mode loads the current line levels, and going to edge mode keeps only requests whose lines are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 8 | Asynchronous interrupt request lines |
| cs_n_i | input | 1 | Chip select for register access, active low |
| rd_i | input | 1 | Read strobe, one cycle |
| wr_i | input | 1 | Write strobe, one cycle |
| addr_i | input | 1 | Register/command select |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| inta_i | input | 1 | Acknowledge pulse, one cycle per pulse |
| int_o | output | 1 | Interrupt to processor |
| vec_o | output | 8 | Vector byte |
| vec_valid_o | output | 1 | Vector valid for one cycle |

## Verification
An end-of-interrupt write and the first acknowledge pulse can land in the same clock edge, and both modify the in-service register. The bench sets line 3 in service, raises line 1 so that it preempts, then drives `inta_i` and the end-of-interrupt write in one cycle. It judges the result by reading back in-service = 8'h02, request = 8'h00 and vector = base|1. Random sequences also mix end-of-interrupt writes, mask changes and acknowledges against a bench model of the registers.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NUM_LINES = 8;
  localparam int IDX_W     = $clog2(NUM_LINES);
  localparam int VEC_W     = 8;
  localparam int BASE_W    = VEC_W - IDX_W;
  localparam int DATA_W    = 8;

  typedef enum logic {ACK_IDLE, ACK_WAIT} ack_state_e;
endpackage

// File: rtl/vic_sync.sv
module vic_sync #(
  parameter int N      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] rise_o
);
  logic [STAGES-1:0][N-1:0] chain_q;
  logic [N-1:0]             prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      prev_q  <= '0;
    end else begin
      chain_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      prev_q <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  oh_o
);
  // lowest index wins: later iterations overwrite
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    oh_o    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o  = 1'b1;
        idx_o    = IW'(i);
        oh_o     = '0;
        oh_o[i]  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_i,
  input  logic                 cs_n_i,
  input  logic                 rd_i,
  input  logic                 wr_i,
  input  logic                 addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic                 inta_i,
  output logic                 int_o,
  output logic [VEC_W-1:0]     vec_o,
  output logic                 vec_valid_o
);
  logic [NUM_LINES-1:0] lvl, rise;
  logic [NUM_LINES-1:0] irr_q, isr_q, imr_q, irr_d, isr_d, pending;
  logic [BASE_W-1:0]    base_q;
  logic                 level_mode_q, sel_isr_q;
  logic [IDX_W-1:0]     ack_idx_q;
  ack_state_e           ack_st_q;

  logic                 win_found, isr_found;
  logic [IDX_W-1:0]     win_idx, isr_idx;
  logic [NUM_LINES-1:0] win_oh, isr_oh;
  logic                 grant, ack_first, ack_second, take;
  logic                 wr_en, rd_en, eoi_cmd, sel_cmd, base_cmd, mode_cmd;

  vic_sync #(.N(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .async_i(irq_i), .level_o(lvl), .rise_o(rise)
  );

  assign pending = irr_q & ~imr_q;

  vic_prio #(.N(NUM_LINES), .IW(IDX_W)) u_prio_req (
    .req_i(pending), .found_o(win_found), .idx_o(win_idx), .oh_o(win_oh)
  );
  vic_prio #(.N(NUM_LINES), .IW(IDX_W)) u_prio_isr (
    .req_i(isr_q), .found_o(isr_found), .idx_o(isr_idx), .oh_o(isr_oh)
  );

  assign grant = win_found && (!isr_found || (win_idx < isr_idx));
  assign int_o = grant;

  assign wr_en    = !cs_n_i && wr_i;
  assign rd_en    = !cs_n_i && rd_i;
  assign eoi_cmd  = wr_en && !addr_i && wdata_i[7];
  assign sel_cmd  = wr_en && !addr_i && (wdata_i[7:6] == 2'b01);
  assign base_cmd = wr_en && !addr_i && (wdata_i[7:5] == 3'b001);
  assign mode_cmd = wr_en && !addr_i && (wdata_i[7:4] == 4'b0001);

  assign ack_first  = inta_i && (ack_st_q == ACK_IDLE);
  assign ack_second = inta_i && (ack_st_q == ACK_WAIT);
  assign take       = ack_first && grant;

  always_comb begin
    irr_d = level_mode_q ? lvl : ((irr_q | rise) & lvl);
    if (take) irr_d = irr_d & ~win_oh;
    isr_d = isr_q;
    if (eoi_cmd) isr_d = isr_d & ~isr_oh;
    if (take)    isr_d = isr_d | win_oh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q        <= '0;
      isr_q        <= '0;
      imr_q        <= '1;
      base_q       <= '0;
      level_mode_q <= 1'b0;
      sel_isr_q    <= 1'b0;
      ack_st_q     <= ACK_IDLE;
      ack_idx_q    <= '0;
      vec_o        <= '0;
      vec_valid_o  <= 1'b0;
      rdata_o      <= '0;
    end else begin
      irr_q       <= irr_d;
      isr_q       <= isr_d;
      vec_valid_o <= ack_second;
      if (wr_en && addr_i) imr_q <= wdata_i;
      if (base_cmd) base_q <= wdata_i[BASE_W-1:0];
      if (mode_cmd) level_mode_q <= wdata_i[0];
      if (sel_cmd)  sel_isr_q <= wdata_i[0];
      if (ack_first) begin
        ack_st_q  <= ACK_WAIT;
        ack_idx_q <= grant ? win_idx : IDX_W'(NUM_LINES - 1);
      end
      if (ack_second) begin
        ack_st_q <= ACK_IDLE;
        vec_o    <= {base_q, ack_idx_q};
      end
      if (rd_en) rdata_o <= addr_i ? imr_q : (sel_isr_q ? isr_q : irr_q);
    end
  end
endmodule

// File: rtl/vic_chk.sv
module vic_chk
  import vic_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cs_n_i,
  input logic                 inta_i,
  input logic                 int_o,
  input logic                 vec_valid_o,
  input logic                 ack_first,
  input logic                 eoi_cmd,
  input logic [NUM_LINES-1:0] isr_q,
  input logic [NUM_LINES-1:0] imr_q,
  input logic [NUM_LINES-1:0] pending
);
  // R5
  int_has_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> (pending != '0));
  // R6
  ack_sets_isr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_first && int_o && !eoi_cmd) |=> ($countones(isr_q) == $past($countones(isr_q)) + 1));
  // R7
  vec_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |=> !vec_valid_o);
  // R7
  vec_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vec_valid_o) |-> $past(inta_i));
  // R8
  eoi_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_cmd && (isr_q != '0) && !ack_first) |=> ($countones(isr_q) == $past($countones(isr_q)) - 1));
  // R9
  cs_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |=> $stable(imr_q));
endmodule

bind vic_top vic_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_n_i(cs_n_i), .inta_i(inta_i),
  .int_o(int_o), .vec_valid_o(vec_valid_o), .ack_first(ack_first),
  .eoi_cmd(eoi_cmd), .isr_q(isr_q), .imr_q(imr_q), .pending(pending)
);

// File: tb/vic_top_bench.sv
module vic_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq = '0;
  logic       cs_n = 1'b1, rd = 1'b0, wr = 1'b0, addr = 1'b0, inta = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, vec;
  logic       intr, vec_valid;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] m_line = 0, m_irr = 0, m_isr = 0, m_imr = 8'hFF;
  logic [4:0] m_base = 0;
  bit         m_level = 0, m_sel = 0;

  always #5 clk = ~clk;

  vic_top u_vic_top (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .cs_n_i(cs_n), .rd_i(rd),
    .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .inta_i(inta), .int_o(intr), .vec_o(vec), .vec_valid_o(vec_valid)
  );

  function automatic int lowest(logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic bit exp_int();
    logic [7:0] p = m_irr & ~m_imr;
    return (p != 0) && (lowest(p) < lowest(m_isr));
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_int(string tag);
    check(intr == exp_int(), tag, intr, exp_int());
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic set_lines(logic [7:0] v);
    irq = v;
    if (m_level) m_irr = v;
    else m_irr = (m_irr | (v & ~m_line)) & v;
    m_line = v;
    settle();
  endtask

  task automatic wr_reg(bit a, logic [7:0] d, bit sel = 0);
    cs_n = sel; wr = 1; addr = a; wdata = d;
    @(negedge clk);
    cs_n = 1; wr = 0;
    if (!sel) begin
      if (a) m_imr = d;
      else if (d[7]) begin
        if (m_isr != 0) m_isr[lowest(m_isr)] = 1'b0;
      end
      else if (d[7:6] == 2'b01) m_sel = d[0];
      else if (d[7:5] == 3'b001) m_base = d[4:0];
      else if (d[7:4] == 4'b0001) begin
        m_level = d[0];
        m_irr = m_level ? m_line : (m_irr & m_line);
      end
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic rd_reg(bit a, logic [7:0] exp, string tag);
    cs_n = 0; rd = 1; addr = a;
    @(negedge clk);
    cs_n = 1; rd = 0;
    check(rdata == exp, tag, rdata, exp);
  endtask

  task automatic ack_seq(string tag);
    int idx;
    logic [7:0] ev;
    if (exp_int()) begin
      idx = lowest(m_irr & ~m_imr);
      m_isr[idx] = 1'b1;
      m_irr[idx] = 1'b0;
    end else idx = 7;
    inta = 1;
    @(negedge clk);
    inta = 0;
    @(negedge clk);
    inta = 1;
    @(negedge clk);
    inta = 0;
    ev = {m_base, 3'(idx)};
    check(vec_valid && vec == ev, tag, {vec_valid, vec}, {1'b1, ev});
    @(negedge clk);
    check(!vec_valid, {tag, " one-cycle valid"}, vec_valid, 0);
    if (m_level) m_irr = m_line;
    settle();
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(intr == 0 && vec_valid == 0 && rdata == 0, "R1 reset outputs", {intr, vec_valid, rdata}, 0);
    rd_reg(1, 8'hFF, "R1 mask reset");
    rd_reg(0, 8'h00, "R1 irr reset");
    // R4 masked line captured but silent
    set_lines(8'h10);
    check_int("R4 masked no int");
    check(intr == 0, "R4 int low", intr, 0);
    rd_reg(0, 8'h10, "R4 masked request visible");
    // R10 mask write
    wr_reg(1, 8'h00);
    rd_reg(1, 8'h00, "R10 mask readback");
    check(intr == 1, "R5 unmasked int", intr, 1);
    wr_reg(0, 8'h20 | 8'h15);
    ack_seq("R7 vector line4");
    wr_reg(0, 8'h41);
    rd_reg(0, 8'h10, "R6 isr bit4");
    wr_reg(0, 8'h40);
    rd_reg(0, 8'h00, "R2 edge cleared after ack while high");
    check(intr == 0, "R2 no re-capture", intr, 0);
    // R5 nesting: line 6 lower, no int; line 2 higher, int
    set_lines(8'h50);
    check(intr == 0, "R5 lower blocked", intr, 0);
    set_lines(8'h54);
    check(intr == 1, "R5 higher preempts", intr, 1);
    ack_seq("R7 vector line2");
    check(intr == 0, "R5 line6 blocked by isr", intr, 0);
    wr_reg(0, 8'h80);
    check(intr == 0, "R8 eoi line2, still line4", intr, 0);
    wr_reg(0, 8'h80);
    check(intr == 1, "R8 eoi releases line6", intr, 1);
    // R2 dropped request
    set_lines(8'h00);
    check(intr == 0, "R2 dropped edge", intr, 0);
    rd_reg(0, 8'h00, "R2 irr empty");
    // R6 spurious
    ack_seq("R6 spurious vector line7");
    wr_reg(0, 8'h41);
    rd_reg(0, 8'h00, "R6 spurious isr unchanged");
    // R9 cs gating
    wr_reg(1, 8'hAA, 1);
    wr_reg(0, 8'h40);
    cs_n = 1; rd = 1; addr = 1;
    @(negedge clk);
    rd = 0;
    check(rdata == 8'h00, "R9 read ignored without cs", rdata, 0);
    rd_reg(1, 8'h00, "R9 mask unchanged");
    // R3 / R11 level mode
    set_lines(8'h01);
    ack_seq("R9 ack without cs");
    wr_reg(0, 8'h80);
    wr_reg(0, 8'h11);
    rd_reg(0, 8'h01, "R11 level loads lines");
    check(intr == 1, "R3 level re-pending", intr, 1);
    ack_seq("R3 level ack");
    rd_reg(0, 8'h01, "R3 level still pending");
    wr_reg(0, 8'h80);
    wr_reg(0, 8'h10);
    rd_reg(0, 8'h01, "R11 edge keeps high request");
    set_lines(8'h00);
    // R8 EOI and ack same cycle
    set_lines(8'h08);
    ack_seq("R8 setup line3");
    set_lines(8'h0A);
    check(intr == 1, "R8 line1 preempts", intr, 1);
    inta = 1; cs_n = 0; wr = 1; addr = 0; wdata = 8'h80;
    @(negedge clk);
    inta = 0; cs_n = 1; wr = 0;
    m_isr = 8'h02; m_irr = 8'h00;
    @(negedge clk);
    inta = 1;
    @(negedge clk);
    inta = 0;
    check(vec_valid && vec == {m_base, 3'd1}, "R8 same-cycle vector", vec, {m_base, 3'd1});
    settle();
    wr_reg(0, 8'h41);
    rd_reg(0, 8'h02, "R8 same-cycle isr");
    wr_reg(0, 8'h40);
    rd_reg(0, 8'h00, "R8 same-cycle irr");
    wr_reg(0, 8'h80);
    set_lines(8'h00);
    // random phase
    for (int n = 0; n < 400; n++) begin
      case ($urandom % 7)
        0, 1: set_lines(8'($urandom));
        2: wr_reg(1, 8'($urandom) & 8'($urandom));
        3: wr_reg(0, 8'h80);
        4: ack_seq("R7 random vector");
        5: begin wr_reg(0, 8'h40 | 8'($urandom % 2)); rd_reg(0, m_sel ? m_isr : m_irr, "R10 random readback"); end
        default: wr_reg(0, 8'h10 | 8'($urandom % 2));
      endcase
      check_int("R5 random int");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule